// File: doc/BRIEF.md
# Full/Empty Tagged Synchronization Memory

This block is a word-addressed store in which each 32-bit data word has a companion presence bit that marks the word as holding a value (full) or not (empty). Beyond plain reads and writes, it offers synchronizing accesses. Each of these checks the presence bit, moves data and updates the bit as one indivisible step. When an access finds the word in the wrong state, the block refuses it. It then reports a trap to the requester and leaves the word and its bit as they were.

A requester presents one request per cycle on a single port: an operation code, a word address and write data. One cycle later the block answers with a ready strobe, read data and a trap flag. A thread can use a consume-style load to wait on a producer, and a fill-once store to avoid overwriting an unread value. The presence bits of the four words that form one line can be read back as a group.

Top module: `fe_sync_mem`

## Requirements
- R1: While reset is asserted and after it is released, every presence bit reads empty, and `rsp_ready` is low until a request has been accepted.
- R2: A request with `req_valid` high at a rising edge is answered at the following edge. `rsp_ready` is high for exactly that one cycle. `rsp_trap` is never high without `rsp_ready`.
- R3: Operation 0 (plain load) returns the word's data and operation 1 (plain store) writes it. Neither operation reads or changes the presence bit. Stores return zero read data.
- R4: Operation 2 (load, trap when empty) returns the data of a full word. On an empty word it traps.
- R5: Operation 3 (consume) returns the data of a full word and marks it empty. On an empty word it traps.
- R6: Operation 4 (fill) always writes the data and marks the word full.
- R7: Operation 5 (fill once) writes the data of an empty word and marks it full. On a full word it traps.
- R8: A trapping access changes neither the data nor the presence bit, and its read data is zero.
- R9: Operation 6 (tag group read) returns in `rsp_rdata[3:0]` the presence bits of the line that holds the addressed word (line = address bits above the low two). The word at line offset k appears in bit k and the upper bits are zero. State is not changed.
- R10: Requests issued on consecutive cycles are handled in order. Each request sees the data and presence state left by the one just before it.
- R11: Operation 7 is reserved. It is answered with zero data and no trap, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7) |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | DATA_W (32) | Store data |
| rsp_ready | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | DATA_W (32) | Load data or line presence group |
| rsp_trap | output | 1 | Access refused because of the presence state |

## Verification
Each synchronizing operation is driven against both a full word and an empty word. This separates the trapping path from the completing path, and a following tag group read or plain load shows whether a refused access left traces. Pairs of dependent requests on adjacent cycles, such as a fill followed by a consume or two consumes in a row, show whether the state update reaches the next request in time. A long mixed stream over a small address window then produces many collisions on the same words and lines, and a behavioural model checks every response in that stream.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_LOAD_CHK  = 3'd2,
    OP_CONSUME   = 3'd3,
    OP_FILL      = 3'd4,
    OP_FILL_ONCE = 3'd5,
    OP_TAG_READ  = 3'd6,
    OP_RESERVED  = 3'd7
  } fe_op_e;

  // Outcome of one access given the current presence bit.
  typedef struct packed {
    logic trap;      // refuse the access
    logic wr_data;   // write store data to the word
    logic set_full;  // mark word full
    logic set_empty; // mark word empty
    logic ret_data;  // return word data
    logic ret_tags;  // return line presence group
  } fe_action_t;

endpackage

// File: rtl/fe_decode.sv
module fe_decode
  import fe_mem_pkg::*;
(
  input  logic [2:0] op,
  input  logic       is_full,
  output fe_action_t act
);

  always_comb begin
    act = '0;
    unique case (fe_op_e'(op))
      OP_LOAD:      act.ret_data = 1'b1;
      OP_STORE:     act.wr_data  = 1'b1;
      OP_LOAD_CHK: begin
        act.trap     = !is_full;
        act.ret_data = is_full;
      end
      OP_CONSUME: begin
        act.trap      = !is_full;
        act.ret_data  = is_full;
        act.set_empty = is_full;
      end
      OP_FILL: begin
        act.wr_data  = 1'b1;
        act.set_full = 1'b1;
      end
      OP_FILL_ONCE: begin
        act.trap     = is_full;
        act.wr_data  = !is_full;
        act.set_full = !is_full;
      end
      OP_TAG_READ:  act.ret_tags = 1'b1;
      default:      act = '0;
    endcase
  end

endmodule

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              set_en,
  input  logic              clr_en,
  output logic [DEPTH-1:0]  tags
);

  logic [DEPTH-1:0] tag_q;
  logic [DEPTH-1:0] tag_d;

  always_comb begin
    tag_d = tag_q;
    if (set_en) tag_d[addr] = 1'b1;
    if (clr_en) tag_d[addr] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else if (set_en || clr_en) tag_q <= tag_d;
  end

  assign tags = tag_q;

  // R6
  tag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tag_q[$past(addr)]);
  // R5
  tag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !tag_q[$past(addr)]);

endmodule

// File: rtl/fe_data_store.sv
module fe_data_store #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_mem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LINE  = 1 << LINE_W;

  logic [DEPTH-1:0]  tag_vec;
  logic              cur_full;
  logic [LINE-1:0]   line_tags;
  logic [ADDR_W-1:0] line_base;
  logic [DATA_W-1:0] word_rd;
  fe_action_t        act;
  logic              data_we, tag_set, tag_clr;

  assign cur_full  = tag_vec[req_addr];
  assign line_base = {req_addr[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
  assign line_tags = tag_vec[line_base +: LINE];

  fe_decode u_decode (
    .op      (req_op),
    .is_full (cur_full),
    .act     (act)
  );

  assign data_we = req_valid && act.wr_data;
  assign tag_set = req_valid && act.set_full;
  assign tag_clr = req_valid && act.set_empty;

  fe_tag_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (req_addr),
    .set_en (tag_set),
    .clr_en (tag_clr),
    .tags   (tag_vec)
  );

  fe_data_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .addr  (req_addr),
    .we    (data_we),
    .wdata (req_wdata),
    .rdata (word_rd)
  );

  // Response registers
  logic              ready_d, trap_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    ready_d = req_valid;
    trap_d  = req_valid && act.trap;
    rdata_d = '0;
    if (req_valid && act.ret_data) rdata_d = word_rd;
    if (req_valid && act.ret_tags) rdata_d = {{(DATA_W-LINE){1'b0}}, line_tags};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= ready_d;
      rsp_trap  <= trap_d;
      rsp_rdata <= rdata_d;
    end
  end

  // R2
  trap_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_ready);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  // R4
  load_empty_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && !cur_full) |=> rsp_trap);
  // R8
  trap_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && act.trap) |=> (tag_vec[$past(req_addr)] == $past(cur_full)));

endmodule

// File: tb/test_fe_sync_mem.sv
module test_fe_sync_mem;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [2:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_ready;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_trap;

  fe_sync_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(2)) i_fe_sync_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_trap  (rsp_trap)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [DATA_W-1:0] ref_data [DEPTH];
  bit                ref_full [DEPTH];

  task automatic check(string rq, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Drive one request at a falling edge, check its response at the next one.
  task automatic do_req(int op, int a, logic [DATA_W-1:0] w, string rq);
    bit                exp_trap = 0;
    logic [DATA_W-1:0] exp_rd   = '0;
    bit                f        = ref_full[a];
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_addr  = ADDR_W'(a);
    req_wdata = w;
    case (op)
      0: exp_rd = ref_data[a];
      1: ref_data[a] = w;
      2: if (!f) exp_trap = 1; else exp_rd = ref_data[a];
      3: if (!f) exp_trap = 1; else begin exp_rd = ref_data[a]; ref_full[a] = 0; end
      4: begin ref_data[a] = w; ref_full[a] = 1; end
      5: if (f) exp_trap = 1; else begin ref_data[a] = w; ref_full[a] = 1; end
      6: for (int k = 0; k < 4; k++) exp_rd[k] = ref_full[(a & ~3) + k];
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, "ready", {31'b0, rsp_ready}, 32'd1);
    check(rq, "trap",  {31'b0, rsp_trap},  {31'b0, exp_trap});
    check(rq, "rdata", rsp_rdata, exp_rd);
  endtask

  task automatic idle(string rq);
    @(negedge clk);
    check(rq, "idle ready", {31'b0, rsp_ready}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < DEPTH; i++) ref_full[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", {31'b0, rsp_ready}, 32'd0);
    rst_n = 1'b1;
    idle("R1");

    // R1 R9: all lines empty after reset
    for (int l = 0; l < DEPTH; l += 4) do_req(6, l + 1, '0, "R1");

    // R3: plain stores fill data, bits stay empty
    for (int i = 0; i < DEPTH; i++) do_req(1, i, 32'hA500_0000 + i, "R3");
    do_req(0, 5, '0, "R3");
    do_req(6, 5, '0, "R3");

    // R4 R8: load-check on empty word traps
    do_req(2, 8, '0, "R4");
    do_req(0, 8, '0, "R8");
    // R6: fill marks full, R4 load-check then succeeds
    do_req(4, 8, 32'h1234_5678, "R6");
    do_req(2, 8, '0, "R4");
    do_req(6, 9, '0, "R9");
    // R7 R8: fill-once on full word refused
    do_req(5, 8, 32'hDEAD_BEEF, "R7");
    do_req(0, 8, '0, "R8");
    // R3: plain store to full word keeps it full
    do_req(1, 8, 32'h0BAD_F00D, "R3");
    do_req(6, 8, '0, "R3");
    // R5 R10: consume then consume back to back
    do_req(3, 8, '0, "R5");
    do_req(3, 8, '0, "R10");
    // R7: fill-once on empty word writes
    do_req(5, 10, 32'hCAFE_0010, "R7");
    do_req(0, 10, '0, "R7");
    // R10: fill followed at once by consume
    do_req(4, 11, 32'h7777_0011, "R10");
    do_req(3, 11, '0, "R10");
    idle("R2");
    // R11: reserved op changes nothing
    do_req(4, 12, 32'h0000_0C0C, "R11");
    do_req(7, 12, 32'hFFFF_FFFF, "R11");
    do_req(6, 12, '0, "R11");
    do_req(0, 12, '0, "R11");
    // R9: line group bit order
    do_req(4, 17, 32'h11, "R9");
    do_req(4, 19, 32'h13, "R9");
    do_req(6, 16, '0, "R9");

    // R10 R2: mixed stream over a small window
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 7));
      int a  = int'($urandom_range(0, 7));
      do_req(op, a, $urandom, "R10");
      if ((n % 37) == 0) idle("R2");
    end
    for (int a = 0; a < 8; a += 4) do_req(6, a, '0, "R9");

    idle("R2");
    finish_run();
  end

endmodule